// File: doc/BRIEF.md
# Serial Link Bring-Up Sequencer

This block brings a serial storage link from an unknown state to an established connection without software help. A single start pulse makes it read the PHY's control register. If the detect field already shows the idle (no-action) code, the reset steps are skipped. Otherwise the block forces a detect reset and then releases it back to idle. Each of these writes is confirmed by reading the register back, inside bounded retry loops. The block then polls the PHY status register until it reports an established link at either generation. When the link is up, it clears any latched error bits by writing back the error word it just read.

All PHY access goes through a single 32-bit register port with a valid/ready request and a response strobe. At most one access is in flight at any time. Delays are counted in microseconds from a parameterised clocks-per-microsecond divider. At the end the block gives a one-cycle done pulse, a connected flag, a generation-2 flag and the number of failed polls. The number of failed polls times the poll interval gives the connect time.

Top module: `link_bringup_seq`

## Requirements
- R1: After reset, done, connected, link_gen2 and conn_polls are all zero and no register request is raised.
- R2: On an accepted start the first access is a read of the control register (address 2). If bits [3:0] (the detect field) read 0, no control write is issued and status polling begins at once.
- R3: The reset phase writes 0x0000_0001 to control, waits at least RESET_US microseconds, then reads control back. It stops early once the detect field reads 1, and makes at most RST_TRIES writes per pass.
- R4: After the reset phase the block waits SETTLE_US microseconds. It then writes 0x0000_0300 to control (detect 0, with bit 8 and bit 9 disabling the two low-power states), waits RESET_US and reads control back. It moves to polling when the detect field reads 0, and makes at most IDLE_TRIES writes per pass.
- R5: If every idle write of a pass fails, the whole reset-and-idle pass repeats, up to OUTER_TRIES passes. After the last failed pass the block finishes with connected low, and it issues no status read.
- R6: Polling reads the status register (address 0) at least POLL_US microseconds apart, with at most MAX_POLLS reads. A read succeeds when bits [7:0] equal 0x13 (generation 1) or 0x23 (generation 2). If all reads fail, the block finishes with connected low.
- R7: After a successful poll the block reads the error register (address 1) and writes the same 32-bit value back to it once. It then finishes with connected high.
- R8: At finish, conn_polls equals the number of failed status reads before the successful one. link_gen2 is high only when the successful code was 0x23.
- R9: A request stays asserted with stable address, write flag and data until ready is seen. No new request is raised until the response strobe for the previous access has arrived, and writes also receive a response.
- R10: done is a one-cycle pulse. A start while a sequence runs is ignored. The results hold until the next accepted start, and writes only go to addresses 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Start pulse, taken when idle |
| phy_req_valid | output | 1 | Register request valid |
| phy_req_ready | input | 1 | PHY accepts request |
| phy_req_write | output | 1 | 1 = write, 0 = read |
| phy_req_addr | output | 2 | 0 status, 1 error, 2 control |
| phy_req_wdata | output | 32 | Write data |
| phy_rsp_valid | input | 1 | Response strobe, one per access |
| phy_rsp_rdata | input | 32 | Read data, valid with the strobe |
| done | output | 1 | One-cycle end-of-sequence pulse |
| connected | output | 1 | Link established and errors cleared |
| link_gen2 | output | 1 | Link came up at generation 2 |
| conn_polls | output | 7 | Failed polls before success |

## Verification
A wrong loop counter or a wrong exit condition does not show on the result flags alone. It shows as the wrong number of reset writes, idle writes or status reads seen by the PHY model by the time done pulses. The bench therefore compares those counts with its own prediction for each scenario. A timer that is too short shows as a gap between a control write and its readback, or between two polls, that is smaller than the programmed delay. A broken handshake shows on the very next access, as a request that changes or overlaps an outstanding response.

// File: rtl/link_seq_pkg.sv
package link_seq_pkg;
   typedef enum logic [3:0] {
      S_IDLE, S_CHK_RD, S_RST_WR, S_RST_WAIT, S_RST_RD, S_SETTLE,
      S_IDL_WR, S_IDL_WAIT, S_IDL_RD, S_POLL_RD, S_POLL_WAIT,
      S_ERR_RD, S_ERR_WR, S_FINISH
   } seq_state_e;

   typedef enum logic [1:0] {P_IDLE, P_REQ, P_RSP} port_state_e;

   localparam logic [1:0]  ADDR_STATUS  = 2'd0;
   localparam logic [1:0]  ADDR_ERROR   = 2'd1;
   localparam logic [1:0]  ADDR_CONTROL = 2'd2;
   localparam logic [3:0]  DET_NONE     = 4'h0;
   localparam logic [3:0]  DET_FORCE    = 4'h1;
   localparam logic [31:0] CTRL_FORCE_WORD   = 32'h0000_0001;
   localparam logic [31:0] CTRL_RELEASE_WORD = 32'h0000_0300;
   localparam logic [7:0]  LINK_UP_G1   = 8'h13;
   localparam logic [7:0]  LINK_UP_G2   = 8'h23;
endpackage

// File: rtl/lseq_us_timer.sv
module lseq_us_timer #(
   parameter int CLK_PER_US = 125,
   parameter int US_W       = 14
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            load,
   input  logic [US_W-1:0] len_us,
   output logic            expired
);
   localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;

   logic            active;
   logic            us_tick;
   logic [US_W-1:0] remain;

   generate
      if (CLK_PER_US < 1) begin : g_bad_div
         $error("CLK_PER_US must be at least 1");
      end
      if (CLK_PER_US == 1) begin : g_direct
         assign us_tick = 1'b1;
      end else begin : g_presc
         logic [PW-1:0] presc;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          presc <= '0;
            else if (load)                       presc <= '0;
            else if (active) begin
               if (presc == PW'(CLK_PER_US - 1)) presc <= '0;
               else                              presc <= presc + 1'b1;
            end
         end
         assign us_tick = (presc == PW'(CLK_PER_US - 1));
      end
   endgenerate

   assign expired = active && us_tick && (remain <= US_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         active <= 1'b0;
         remain <= '0;
      end else if (load) begin
         active <= 1'b1;
         remain <= len_us;
      end else if (active && us_tick) begin
         if (remain <= US_W'(1)) active <= 1'b0;
         else                    remain <= remain - 1'b1;
      end
   end
endmodule

// File: rtl/lseq_reg_port.sv
module lseq_reg_port
   import link_seq_pkg::*;
#(
   parameter int DW = 32,
   parameter int AW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          go,
   input  logic          go_write,
   input  logic [AW-1:0] go_addr,
   input  logic [DW-1:0] go_wdata,
   output logic          acc_done,
   output logic [DW-1:0] acc_rdata,
   output logic          req_valid,
   input  logic          req_ready,
   output logic          req_write,
   output logic [AW-1:0] req_addr,
   output logic [DW-1:0] req_wdata,
   input  logic          rsp_valid,
   input  logic [DW-1:0] rsp_rdata
);
   port_state_e st;

   assign acc_done  = (st == P_RSP) && rsp_valid;
   assign acc_rdata = rsp_rdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st        <= P_IDLE;
         req_valid <= 1'b0;
         req_write <= 1'b0;
         req_addr  <= '0;
         req_wdata <= '0;
      end else begin
         case (st)
            P_IDLE: if (go) begin
               st        <= P_REQ;
               req_valid <= 1'b1;
               req_write <= go_write;
               req_addr  <= go_addr;
               req_wdata <= go_wdata;
            end
            P_REQ: if (req_ready) begin
               st        <= P_RSP;
               req_valid <= 1'b0;
            end
            P_RSP: if (rsp_valid) st <= P_IDLE;
            default: st <= P_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/link_bringup_seq.sv
module link_bringup_seq
   import link_seq_pkg::*;
#(
   parameter int CLK_PER_US  = 125,
   parameter int RESET_US    = 100,
   parameter int SETTLE_US   = 5000,
   parameter int POLL_US     = 10000,
   parameter int RST_TRIES   = 10,
   parameter int IDLE_TRIES  = 10,
   parameter int OUTER_TRIES = 10,
   parameter int MAX_POLLS   = 100
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        start,
   output logic        phy_req_valid,
   input  logic        phy_req_ready,
   output logic        phy_req_write,
   output logic [1:0]  phy_req_addr,
   output logic [31:0] phy_req_wdata,
   input  logic        phy_rsp_valid,
   input  logic [31:0] phy_rsp_rdata,
   output logic        done,
   output logic        connected,
   output logic        link_gen2,
   output logic [6:0]  conn_polls
);
   localparam int MAX_A  = (RESET_US > SETTLE_US) ? RESET_US : SETTLE_US;
   localparam int MAX_US = (MAX_A > POLL_US) ? MAX_A : POLL_US;
   localparam int US_W   = $clog2(MAX_US + 1);
   localparam int MAX_IN = (RST_TRIES > IDLE_TRIES) ? RST_TRIES : IDLE_TRIES;
   localparam int IN_W   = $clog2(MAX_IN + 1);
   localparam int OUT_W  = $clog2(OUTER_TRIES + 1);

   generate
      if (MAX_POLLS < 1 || MAX_POLLS > 127) begin : g_bad_polls
         $error("MAX_POLLS must lie in 1..127");
      end
      if (RST_TRIES < 1 || IDLE_TRIES < 1 || OUTER_TRIES < 1) begin : g_bad_tries
         $error("retry counts must be at least 1");
      end
      if (RESET_US < 1 || SETTLE_US < 1 || POLL_US < 1) begin : g_bad_delay
         $error("delays must be at least 1 us");
      end
   endgenerate

   seq_state_e         state;
   logic               pend;
   logic [IN_W-1:0]    inner;
   logic [OUT_W-1:0]   outer;
   logic [6:0]         polls;
   logic [31:0]        err_q;
   logic               g2_seen;

   logic               acc_go, acc_wr, acc_done;
   logic [1:0]         acc_addr;
   logic [31:0]        acc_wdata, acc_rdata;
   logic               tmr_load, tmr_exp;
   logic [US_W-1:0]    tmr_len;
   logic [3:0]         det_rd;
   logic [7:0]         link_rd;

   assign det_rd  = acc_rdata[3:0];
   assign link_rd = acc_rdata[7:0];
   assign done    = (state == S_FINISH);

   lseq_reg_port #(.DW(32), .AW(2)) u_port (
      .clk       (clk),
      .rst_n     (rst_n),
      .go        (acc_go),
      .go_write  (acc_wr),
      .go_addr   (acc_addr),
      .go_wdata  (acc_wdata),
      .acc_done  (acc_done),
      .acc_rdata (acc_rdata),
      .req_valid (phy_req_valid),
      .req_ready (phy_req_ready),
      .req_write (phy_req_write),
      .req_addr  (phy_req_addr),
      .req_wdata (phy_req_wdata),
      .rsp_valid (phy_rsp_valid),
      .rsp_rdata (phy_rsp_rdata)
   );

   lseq_us_timer #(.CLK_PER_US(CLK_PER_US), .US_W(US_W)) u_tmr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load    (tmr_load),
      .len_us  (tmr_len),
      .expired (tmr_exp)
   );

   always_comb begin
      acc_go    = 1'b0;
      acc_wr    = 1'b0;
      acc_addr  = ADDR_CONTROL;
      acc_wdata = '0;
      tmr_load  = 1'b0;
      tmr_len   = US_W'(RESET_US);
      case (state)
         S_CHK_RD, S_RST_RD, S_IDL_RD: acc_go = !pend;
         S_RST_WR: begin
            acc_go = !pend; acc_wr = 1'b1; acc_wdata = CTRL_FORCE_WORD;
         end
         S_IDL_WR: begin
            acc_go = !pend; acc_wr = 1'b1; acc_wdata = CTRL_RELEASE_WORD;
         end
         S_POLL_RD: begin
            acc_go = !pend; acc_addr = ADDR_STATUS;
         end
         S_ERR_RD: begin
            acc_go = !pend; acc_addr = ADDR_ERROR;
         end
         S_ERR_WR: begin
            acc_go = !pend; acc_wr = 1'b1; acc_addr = ADDR_ERROR; acc_wdata = err_q;
         end
         S_RST_WAIT, S_IDL_WAIT: tmr_load = !pend;
         S_SETTLE: begin
            tmr_load = !pend; tmr_len = US_W'(SETTLE_US);
         end
         S_POLL_WAIT: begin
            tmr_load = !pend; tmr_len = US_W'(POLL_US);
         end
         default: ;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= S_IDLE;
         pend       <= 1'b0;
         inner      <= '0;
         outer      <= '0;
         polls      <= '0;
         err_q      <= '0;
         g2_seen    <= 1'b0;
         connected  <= 1'b0;
         link_gen2  <= 1'b0;
         conn_polls <= '0;
      end else begin
         if (acc_done || tmr_exp)      pend <= 1'b0;
         else if (acc_go || tmr_load)  pend <= 1'b1;

         case (state)
            S_IDLE: if (start) begin
               state      <= S_CHK_RD;
               outer      <= '0;
               inner      <= '0;
               polls      <= '0;
               connected  <= 1'b0;
               link_gen2  <= 1'b0;
               conn_polls <= '0;
            end
            S_CHK_RD: if (acc_done) begin
               inner <= '0;
               polls <= '0;
               state <= (det_rd == DET_NONE) ? S_POLL_RD : S_RST_WR;
            end
            S_RST_WR:   if (acc_done) state <= S_RST_WAIT;
            S_RST_WAIT: if (tmr_exp)  state <= S_RST_RD;
            S_RST_RD: if (acc_done) begin
               if (det_rd == DET_FORCE || inner == IN_W'(RST_TRIES - 1)) begin
                  inner <= '0;
                  state <= S_SETTLE;
               end else begin
                  inner <= inner + 1'b1;
                  state <= S_RST_WR;
               end
            end
            S_SETTLE:   if (tmr_exp)  state <= S_IDL_WR;
            S_IDL_WR:   if (acc_done) state <= S_IDL_WAIT;
            S_IDL_WAIT: if (tmr_exp)  state <= S_IDL_RD;
            S_IDL_RD: if (acc_done) begin
               if (det_rd == DET_NONE) begin
                  polls <= '0;
                  state <= S_POLL_RD;
               end else if (inner == IN_W'(IDLE_TRIES - 1)) begin
                  inner <= '0;
                  if (outer == OUT_W'(OUTER_TRIES - 1)) begin
                     state <= S_FINISH;
                  end else begin
                     outer <= outer + 1'b1;
                     state <= S_RST_WR;
                  end
               end else begin
                  inner <= inner + 1'b1;
                  state <= S_IDL_WR;
               end
            end
            S_POLL_RD: if (acc_done) begin
               if (link_rd == LINK_UP_G1 || link_rd == LINK_UP_G2) begin
                  g2_seen <= (link_rd == LINK_UP_G2);
                  state   <= S_ERR_RD;
               end else begin
                  state <= S_POLL_WAIT;
               end
            end
            S_POLL_WAIT: if (tmr_exp) begin
               if (polls == 7'(MAX_POLLS - 1)) begin
                  state <= S_FINISH;
               end else begin
                  polls <= polls + 1'b1;
                  state <= S_POLL_RD;
               end
            end
            S_ERR_RD: if (acc_done) begin
               err_q <= acc_rdata;
               state <= S_ERR_WR;
            end
            S_ERR_WR: if (acc_done) begin
               connected  <= 1'b1;
               link_gen2  <= g2_seen;
               conn_polls <= polls;
               state      <= S_FINISH;
            end
            S_FINISH: state <= S_IDLE;
            default:  state <= S_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/lseq_checker.sv
module lseq_checker #(
   parameter int MAX_POLLS = 100
) (
   input logic        clk,
   input logic        rst_n,
   input logic        phy_req_valid,
   input logic        phy_req_ready,
   input logic        phy_req_write,
   input logic [1:0]  phy_req_addr,
   input logic [31:0] phy_req_wdata,
   input logic        phy_rsp_valid,
   input logic        done,
   input logic        connected,
   input logic        link_gen2,
   input logic [6:0]  conn_polls
);
   logic outstanding;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                              outstanding <= 1'b0;
      else if (phy_req_valid && phy_req_ready) outstanding <= 1'b1;
      else if (phy_rsp_valid)                  outstanding <= 1'b0;
   end

   a_r9_req_held: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_valid && !phy_req_ready |=> phy_req_valid && $stable(phy_req_addr)
         && $stable(phy_req_write) && $stable(phy_req_wdata));

   a_r9_single_outstanding: assert property (@(posedge clk) disable iff (!rst_n)
      outstanding |-> !phy_req_valid);

   a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   a_r10_quiet_at_done: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !phy_req_valid && !outstanding);

   a_r10_write_targets: assert property (@(posedge clk) disable iff (!rst_n)
      phy_req_valid && phy_req_write |-> phy_req_addr == 2'd1 || phy_req_addr == 2'd2);

   a_r8_gen2_needs_link: assert property (@(posedge clk) disable iff (!rst_n)
      link_gen2 |-> connected);

   a_r8_poll_count_range: assert property (@(posedge clk) disable iff (!rst_n)
      connected |-> conn_polls < 7'(MAX_POLLS));
endmodule

bind link_bringup_seq lseq_checker #(.MAX_POLLS(MAX_POLLS)) u_lseq_checker (
   .clk           (clk),
   .rst_n         (rst_n),
   .phy_req_valid (phy_req_valid),
   .phy_req_ready (phy_req_ready),
   .phy_req_write (phy_req_write),
   .phy_req_addr  (phy_req_addr),
   .phy_req_wdata (phy_req_wdata),
   .phy_rsp_valid (phy_rsp_valid),
   .done          (done),
   .connected     (connected),
   .link_gen2     (link_gen2),
   .conn_polls    (conn_polls)
);

// File: tb/tb_link_bringup_seq.sv
module tb_link_bringup_seq;
   localparam int CPU = 2, RST_D = 5, SET_D = 20, POLL_D = 10;

   logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
   logic phy_req_valid, phy_req_write, done, connected, link_gen2;
   logic phy_req_ready = 1'b0, phy_rsp_valid = 1'b0;
   logic [1:0] phy_req_addr;
   logic [31:0] phy_req_wdata, phy_rsp_rdata = '0;
   logic [6:0] conn_polls;

   int checks = 0, errors = 0, cyc = 0;

   int m_rst_need, m_idle_need, m_link_need;
   logic [7:0] m_code;
   logic [3:0] det_view;
   logic [31:0] err_reg, err_wr_val;
   int rw, iw, sr, err_wr_cnt, bad_acc;
   int last_ctrl_wr, last_stat_rd, min_ctrl_gap, min_poll_gap;
   logic cap_wr; logic [1:0] cap_addr; logic [31:0] cap_wdata;

   always #4 clk = ~clk;

   link_bringup_seq #(.CLK_PER_US(CPU), .RESET_US(RST_D), .SETTLE_US(SET_D),
                      .POLL_US(POLL_D)) dut (.*);

   task automatic chk(input bit ok, input string req, input string what,
                      input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // PHY register model, driven away from the active edge
   initial begin
      forever begin
         @(negedge clk);
         cyc++;
         phy_rsp_valid = 1'b0;
         if (phy_req_ready) begin
            phy_req_ready = 1'b0;
            phy_rsp_rdata = 32'h0;
            if (cap_addr == 2'd2 && cap_wr) begin
               last_ctrl_wr = cyc;
               if (cap_wdata == 32'h1) begin
                  rw++; det_view = (rw >= m_rst_need) ? 4'h1 : 4'h4;
               end else if (cap_wdata == 32'h300) begin
                  iw++; det_view = (iw >= m_idle_need) ? 4'h0 : 4'h1;
               end else bad_acc++;
            end else if (cap_addr == 2'd2) begin
               phy_rsp_rdata = {28'h0, det_view};
            end else if (cap_addr == 2'd0 && !cap_wr) begin
               sr++;
               phy_rsp_rdata = (sr >= m_link_need) ? {24'h5a5a5a, m_code} : 32'h5a5a5a01;
            end else if (cap_addr == 2'd1 && !cap_wr) begin
               phy_rsp_rdata = err_reg;
            end else if (cap_addr == 2'd1) begin
               err_wr_cnt++; err_wr_val = cap_wdata; err_reg = err_reg & ~cap_wdata;
            end else bad_acc++;
            phy_rsp_valid = 1'b1;
         end else if (phy_req_valid && ($urandom % 3 != 0)) begin
            cap_wr = phy_req_write; cap_addr = phy_req_addr; cap_wdata = phy_req_wdata;
            if (cap_addr == 2'd2 && !cap_wr && last_ctrl_wr >= 0
                && cyc - last_ctrl_wr < min_ctrl_gap) min_ctrl_gap = cyc - last_ctrl_wr;
            if (cap_addr == 2'd0 && !cap_wr) begin
               if (last_stat_rd >= 0 && cyc - last_stat_rd < min_poll_gap)
                  min_poll_gap = cyc - last_stat_rd;
               last_stat_rd = cyc;
            end
            phy_req_ready = 1'b1;
         end
      end
   end

   task automatic predict(input int init_det, input int rn, input int idn, input int ln,
                          input logic [7:0] code, output int e_conn, output int e_g2,
                          output int e_polls, output int e_rw, output int e_iw,
                          output int e_sr);
      bit up = (init_det == 0);
      e_conn = 0; e_g2 = 0; e_polls = 0; e_rw = 0; e_iw = 0; e_sr = 0;
      for (int o = 0; o < 10 && !up; o++) begin
         for (int l = 0; l < 10; l++) begin
            e_rw++;
            if (e_rw >= rn) break;
         end
         for (int l = 0; l < 10; l++) begin
            e_iw++;
            if (e_iw >= idn) begin up = 1; break; end
         end
      end
      if (up) begin
         for (int p = 0; p < 100; p++) begin
            e_sr++;
            if (e_sr >= ln && (code == 8'h13 || code == 8'h23)) begin
               e_conn = 1; e_g2 = (code == 8'h23); e_polls = p; break;
            end
         end
      end
   endtask

   task automatic run(input int init_det, input int rn, input int idn, input int ln,
                      input logic [7:0] code, input logic [31:0] err, input bit poke);
      int e_conn, e_g2, e_polls, e_rw, e_iw, e_sr;
      predict(init_det, rn, idn, ln, code, e_conn, e_g2, e_polls, e_rw, e_iw, e_sr);
      m_rst_need = rn; m_idle_need = idn; m_link_need = ln; m_code = code;
      det_view = init_det[3:0]; err_reg = err; err_wr_val = '0;
      rw = 0; iw = 0; sr = 0; err_wr_cnt = 0; bad_acc = 0;
      last_ctrl_wr = -1; last_stat_rd = -1;
      @(negedge clk); start = 1'b1;
      @(negedge clk); start = 1'b0;
      if (poke) begin
         repeat (25) @(negedge clk);
         start = 1'b1; @(negedge clk); start = 1'b0;
      end
      while (!done) @(negedge clk);
      chk(connected == e_conn[0], "R5/R6", "connected", connected, e_conn);
      chk(link_gen2 == e_g2[0], "R8", "link_gen2", link_gen2, e_g2);
      chk(conn_polls == 7'(e_polls), "R8", "conn_polls", conn_polls, e_polls);
      chk(rw == e_rw, poke ? "R10" : "R3", "reset writes", rw, e_rw);
      chk(iw == e_iw, "R4", "idle writes", iw, e_iw);
      chk(sr == e_sr, "R6", "status reads", sr, e_sr);
      if (init_det == 0) chk(rw + iw == 0, "R2", "control writes on skip", rw + iw, 0);
      chk(err_wr_cnt == e_conn, "R7", "error writes", err_wr_cnt, e_conn);
      if (e_conn != 0) begin
         chk(err_wr_val == err, "R7", "error write value", err_wr_val, err);
         chk(err_reg == 0, "R7", "error reg cleared", err_reg, 0);
      end
      chk(bad_acc == 0, "R10", "illegal accesses", bad_acc, 0);
      @(negedge clk);
      chk(!done, "R10", "done width", done, 0);
      repeat (4) @(negedge clk);
      chk(connected == e_conn[0] && !phy_req_valid, "R10", "hold after done",
          connected, e_conn);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      min_ctrl_gap = 1 << 30; min_poll_gap = 1 << 30;
      repeat (3) @(negedge clk);
      chk(!done && !connected && !link_gen2 && conn_polls == 0 && !phy_req_valid,
          "R1", "reset state", {done, connected, link_gen2, phy_req_valid}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      // directed corners
      run(0, 1, 1, 1, 8'h13, 32'h0000_0f00, 0);    // R2 skip, immediate gen1
      run(4, 1, 1, 5, 8'h23, 32'h8000_0001, 0);    // R8 gen2 after 4 misses
      run(4, 3, 2, 1, 8'h13, 32'h0, 0);            // R3 three reset writes
      run(4, 30, 1, 2, 8'h13, 32'h1234, 0);        // R3 reset never confirmed
      run(4, 1, 15, 1, 8'h23, 32'hffff_ffff, 0);   // R5 second pass
      run(4, 1, 1000, 1, 8'h13, 32'h55, 0);        // R5 every pass fails
      run(0, 1, 1, 200, 8'h13, 32'h7, 0);          // R6 poll timeout
      run(0, 1, 1, 1, 8'h03, 32'h7, 0);            // R6 wrong code ignored
      run(0, 1, 1, 100, 8'h23, 32'h9, 0);          // R8 last poll succeeds
      run(4, 1, 3, 2, 8'h13, 32'h3, 1);            // R10 start while busy
      for (int i = 0; i < 12; i++) begin
         int sel = $urandom % 3;
         run(($urandom % 2) ? 4 : 0, 1 + $urandom % 12, 1 + $urandom % 25,
             1 + $urandom % 60, (sel == 0) ? 8'h13 : (sel == 1) ? 8'h23 : 8'h03,
             $urandom, 0);
      end
      chk(min_ctrl_gap >= RST_D * CPU, "R3", "write-to-readback gap",
          min_ctrl_gap, RST_D * CPU);
      chk(min_poll_gap >= POLL_D * CPU, "R6", "poll spacing", min_poll_gap, POLL_D * CPU);
      chk(min_poll_gap < 1 << 30, "R9", "responses seen", min_poll_gap, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule